// File: doc/BRIEF.md
# Packed Halfword Multiply-Accumulate Unit

This block is the multiply datapath of a packed-integer SIMD pipe. Each operand is 64 bits wide, seen as four 16-bit lanes (or, for one reduction, as eight byte lanes). A 4-bit opcode chooses one operation from a fixed set:

- lane-parallel multiplies that keep either the low or the high half of each 32-bit product
- pairwise multiply-adds that fold two lane products into each 32-bit half of the result
- full four-lane multiply-accumulate reductions
- sum-of-absolute-difference reductions over bytes or halfwords
- scalar multiply-adds that add one or two signed halfword products onto a 64-bit accumulator input

Most operations come in a signed and an unsigned form, and the opcode picks the interpretation of the lanes.

The datapath between the operand ports and the result register is combinational. The unit captures the result on the rising clock edge whenever `in_valid` is high, and it raises `out_valid` one cycle later. A new operation can be issued on every cycle.

Top module: `simd_mac_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `result` becomes zero and `out_valid` becomes low, even if `in_valid` is high.
- R2: `out_valid` equals the value `in_valid` had at the previous edge, and `result` keeps its value whenever `in_valid` was low.
- R3: Opcodes 0 (unsigned) and 1 (signed) place bits [15:0] of the 32-bit product of lane i of `src_a` and lane i of `src_b` into result bits [16i+15:16i], where lane i is bits [16i+15:16i].
- R4: Opcodes 2 (unsigned) and 3 (signed) place bits [31:16] of each lane product into that lane's result bits.
- R5: Opcodes 4 (unsigned) and 5 (signed) put the sum of the lane 0 and lane 1 products, truncated to 32 bits, into result[31:0], and the truncated sum of the lane 2 and lane 3 products into result[63:32].
- R6: Opcode 6 returns the sum of the four unsigned lane products as a zero-extended 64-bit value.
- R7: Opcode 7 returns the sum of the four signed lane products, sign-extended to 64 bits.
- R8: Opcode 8 returns the sum of the absolute differences of the eight unsigned byte pairs (byte j is bits [8j+7:8j]), zero-extended to 64 bits.
- R9: Opcode 9 returns the sum of the absolute differences of the four unsigned halfword pairs, zero-extended to 64 bits.
- R10: Opcode 10 returns `acc_in` plus the sign-extended signed product of `src_a[15:0]` and `src_b[15:0]`, modulo 2^64.
- R11: Opcode 11 returns `acc_in` plus the sign-extended signed products of lanes 0 and 1, modulo 2^64; bits [63:32] of both operands have no effect.
- R12: Opcodes 12 to 15 produce a zero result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Issues the operation on the operand ports this cycle |
| opcode | input | 4 | Operation select, codes listed in R3 to R12 |
| src_a | input | 64 | First packed operand |
| src_b | input | 64 | Second packed operand |
| acc_in | input | 64 | Accumulator addend for opcodes 10 and 11 |
| out_valid | output | 1 | Result register holds a newly computed value |
| result | output | 64 | Registered operation result |

## Verification
Two events can meet at the same clock edge. The first is capturing a new operation while the previous result is still on the output. The second is a reset arriving together with an asserted `in_valid`.

Both the vector table and a long random run issue operations back to back. On each cycle the bench checks the result of the previous operation while it drives the next one, so a stale or shifted capture gives a mismatch against the model. A directed test raises `rst` in the same cycle as a valid signed multiply-accumulate of nonzero operands. It expects a zero result and a low `out_valid` on the next cycle, which shows that reset takes precedence over capture.

// File: rtl/simd_mac_pkg.sv
package simd_mac_pkg;
  localparam int LANE_W  = 16;
  localparam int LANES   = 4;
  localparam int DATA_W  = LANE_W * LANES;
  localparam int BYTE_W  = 8;
  localparam int BYTES   = DATA_W / BYTE_W;
  localparam int PROD_W  = 2 * LANE_W + 2;
  localparam int OP_W    = 4;

  typedef enum logic [OP_W-1:0] {
    OP_MULLO_U = 4'd0,
    OP_MULLO_S = 4'd1,
    OP_MULHI_U = 4'd2,
    OP_MULHI_S = 4'd3,
    OP_PAIR_U  = 4'd4,
    OP_PAIR_S  = 4'd5,
    OP_MAC_U   = 4'd6,
    OP_MAC_S   = 4'd7,
    OP_SAD_B   = 4'd8,
    OP_SAD_H   = 4'd9,
    OP_ACC_ONE = 4'd10,
    OP_ACC_TWO = 4'd11
  } mac_op_e;

  function automatic logic op_signed(input logic [OP_W-1:0] op);
    return (op == OP_MULLO_S) || (op == OP_MULHI_S) || (op == OP_PAIR_S) ||
           (op == OP_MAC_S) || (op == OP_ACC_ONE) || (op == OP_ACC_TWO);
  endfunction
endpackage

// File: rtl/simd_lane_mult.sv
module simd_lane_mult #(
  parameter int LANE_W = simd_mac_pkg::LANE_W,
  parameter int LANES  = simd_mac_pkg::LANES,
  localparam int DATA_W = LANE_W * LANES,
  localparam int PROD_W = 2 * LANE_W + 2
) (
  input  logic                           is_signed,
  input  logic [DATA_W-1:0]              op_a,
  input  logic [DATA_W-1:0]              op_b,
  output logic [LANES-1:0][PROD_W-1:0]   prods
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0]        la, lb;
    logic                     ea, eb;
    logic signed [PROD_W-1:0] xa, xb, pr;
    assign la = op_a[i*LANE_W +: LANE_W];
    assign lb = op_b[i*LANE_W +: LANE_W];
    assign ea = is_signed & la[LANE_W-1];
    assign eb = is_signed & lb[LANE_W-1];
    assign xa = {{(PROD_W-LANE_W){ea}}, la};
    assign xb = {{(PROD_W-LANE_W){eb}}, lb};
    assign pr = xa * xb;
    assign prods[i] = pr;
  end
endmodule

// File: rtl/simd_sad.sv
module simd_sad #(
  parameter int DATA_W = simd_mac_pkg::DATA_W,
  parameter int BYTE_W = simd_mac_pkg::BYTE_W,
  parameter int LANE_W = simd_mac_pkg::LANE_W,
  localparam int BYTES  = DATA_W / BYTE_W,
  localparam int LANES  = DATA_W / LANE_W,
  localparam int SB_W   = BYTE_W + $clog2(BYTES),
  localparam int SH_W   = LANE_W + $clog2(LANES)
) (
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  output logic [SB_W-1:0]   sad_byte,
  output logic [SH_W-1:0]   sad_half
);
  logic [BYTES-1:0][BYTE_W-1:0] bdiff;
  logic [LANES-1:0][LANE_W-1:0] hdiff;

  for (genvar j = 0; j < BYTES; j++) begin : g_byte
    logic [BYTE_W-1:0] xa, xb;
    assign xa = op_a[j*BYTE_W +: BYTE_W];
    assign xb = op_b[j*BYTE_W +: BYTE_W];
    assign bdiff[j] = (xa >= xb) ? (xa - xb) : (xb - xa);
  end

  for (genvar i = 0; i < LANES; i++) begin : g_half
    logic [LANE_W-1:0] xa, xb;
    assign xa = op_a[i*LANE_W +: LANE_W];
    assign xb = op_b[i*LANE_W +: LANE_W];
    assign hdiff[i] = (xa >= xb) ? (xa - xb) : (xb - xa);
  end

  always_comb begin
    sad_byte = '0;
    for (int j = 0; j < BYTES; j++) sad_byte = sad_byte + SB_W'(bdiff[j]);
    sad_half = '0;
    for (int i = 0; i < LANES; i++) sad_half = sad_half + SH_W'(hdiff[i]);
  end
endmodule

// File: rtl/simd_mac_select.sv
module simd_mac_select
  import simd_mac_pkg::*;
#(
  parameter int LANE_W = simd_mac_pkg::LANE_W,
  parameter int LANES  = simd_mac_pkg::LANES,
  parameter int BYTE_W = simd_mac_pkg::BYTE_W,
  localparam int DATA_W = LANE_W * LANES,
  localparam int PROD_W = 2 * LANE_W + 2,
  localparam int HALF_W = 2 * LANE_W,
  localparam int SB_W   = BYTE_W + $clog2(DATA_W / BYTE_W),
  localparam int SH_W   = LANE_W + $clog2(LANES)
) (
  input  logic [OP_W-1:0]               op,
  input  logic [LANES-1:0][PROD_W-1:0]  prods,
  input  logic [SB_W-1:0]               sad_byte,
  input  logic [SH_W-1:0]               sad_half,
  input  logic [DATA_W-1:0]             acc,
  output logic [DATA_W-1:0]             nxt
);
  logic [LANES-1:0][DATA_W-1:0] wide;
  logic [DATA_W-1:0]            red_sum;
  logic [HALF_W-1:0]            pair_lo, pair_hi;

  for (genvar i = 0; i < LANES; i++) begin : g_ext
    assign wide[i] = {{(DATA_W-PROD_W){prods[i][PROD_W-1]}}, prods[i]};
  end

  assign pair_lo = prods[0][HALF_W-1:0] + prods[1][HALF_W-1:0];
  assign pair_hi = prods[2][HALF_W-1:0] + prods[3][HALF_W-1:0];

  always_comb begin
    red_sum = '0;
    for (int i = 0; i < LANES; i++) red_sum = red_sum + wide[i];
  end

  always_comb begin
    nxt = '0;
    case (op)
      OP_MULLO_U, OP_MULLO_S:
        for (int i = 0; i < LANES; i++) nxt[i*LANE_W +: LANE_W] = prods[i][LANE_W-1:0];
      OP_MULHI_U, OP_MULHI_S:
        for (int i = 0; i < LANES; i++) nxt[i*LANE_W +: LANE_W] = prods[i][HALF_W-1:LANE_W];
      OP_PAIR_U, OP_PAIR_S: nxt = {pair_hi, pair_lo};
      OP_MAC_U, OP_MAC_S:   nxt = red_sum;
      OP_SAD_B:             nxt = DATA_W'(sad_byte);
      OP_SAD_H:             nxt = DATA_W'(sad_half);
      OP_ACC_ONE:           nxt = acc + wide[0];
      OP_ACC_TWO:           nxt = acc + wide[0] + wide[1];
      default:              nxt = '0;
    endcase
  end
endmodule

// File: rtl/simd_mac_unit.sv
module simd_mac_unit
  import simd_mac_pkg::*;
#(
  parameter int LANE_W = simd_mac_pkg::LANE_W,
  parameter int LANES  = simd_mac_pkg::LANES,
  parameter int BYTE_W = simd_mac_pkg::BYTE_W,
  localparam int DATA_W = LANE_W * LANES,
  localparam int PROD_W = 2 * LANE_W + 2,
  localparam int SB_W   = BYTE_W + $clog2(DATA_W / BYTE_W),
  localparam int SH_W   = LANE_W + $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   opcode,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [DATA_W-1:0] acc_in,
  output logic              out_valid,
  output logic [DATA_W-1:0] result
);
  logic [LANES-1:0][PROD_W-1:0] prods;
  logic [SB_W-1:0]              sad_byte;
  logic [SH_W-1:0]              sad_half;
  logic [DATA_W-1:0]            nxt;

  simd_lane_mult #(.LANE_W(LANE_W), .LANES(LANES)) u_mult (
    .is_signed (op_signed(opcode)),
    .op_a      (src_a),
    .op_b      (src_b),
    .prods     (prods)
  );

  simd_sad #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .LANE_W(LANE_W)) u_sad (
    .op_a     (src_a),
    .op_b     (src_b),
    .sad_byte (sad_byte),
    .sad_half (sad_half)
  );

  simd_mac_select #(.LANE_W(LANE_W), .LANES(LANES), .BYTE_W(BYTE_W)) u_sel (
    .op       (opcode),
    .prods    (prods),
    .sad_byte (sad_byte),
    .sad_half (sad_half),
    .acc      (acc_in),
    .nxt      (nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= nxt;
    end
  end

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r2_idle_drops: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  a_r2_result_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result));
  a_r12_unused_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opcode >= 4'd12) |=> (result == '0));
  a_r8_sad_byte_width: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opcode == OP_SAD_B) |=> (result[DATA_W-1:SB_W] == '0));
  a_r6_macu_nonneg: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opcode == OP_MAC_U) |=> (result[DATA_W-1:PROD_W] == '0));
endmodule

// File: tb/test_simd_mac_unit.sv
`timescale 1ns/1ps
module test_simd_mac_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [3:0]  opcode = '0;
  logic [63:0] src_a = '0, src_b = '0, acc_in = '0;
  logic        out_valid;
  logic [63:0] result;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  simd_mac_unit i_simd_mac_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode),
    .src_a(src_a), .src_b(src_b), .acc_in(acc_in),
    .out_valid(out_valid), .result(result)
  );

  localparam int NV = 16;
  localparam logic [195:0] VECS [NV] = '{
    {4'd0,  64'h0003_FFFF_1234_8000, 64'h0005_FFFF_0010_0002, 64'h0},
    {4'd1,  64'h0003_FFFF_1234_8000, 64'h0005_FFFF_0010_0002, 64'h0},
    {4'd2,  64'hFFFF_7FFF_ABCD_0100, 64'hFFFF_7FFF_4321_0100, 64'h0},
    {4'd3,  64'hFFFF_7FFF_ABCD_0100, 64'hFFFF_7FFF_4321_0100, 64'h0},
    {4'd4,  64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0},
    {4'd5,  64'h8000_7FFF_FFFE_0003, 64'h8000_7FFF_0002_FFFD, 64'h0},
    {4'd6,  64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0},
    {4'd7,  64'hFFFF_0001_8000_7FFF, 64'h0001_FFFF_7FFF_8000, 64'h0},
    {4'd8,  64'h00FF_10F0_0180_7F01, 64'hFF00_F010_8001_017F, 64'h0},
    {4'd9,  64'h0000_FFFF_1000_8000, 64'hFFFF_0000_0FFF_7FFF, 64'h0},
    {4'd10, 64'h5555_5555_5555_FFFF, 64'hAAAA_AAAA_AAAA_0002, 64'h0000_0000_0000_0005},
    {4'd10, 64'h0000_0000_0000_8000, 64'h0000_0000_0000_8000, 64'hFFFF_FFFF_FFFF_FFFF},
    {4'd11, 64'h1234_5678_0003_FFFF, 64'h9ABC_DEF0_0002_0004, 64'h0000_0000_0000_0010},
    {4'd11, 64'h0000_0000_8000_8000, 64'h0000_0000_7FFF_7FFF, 64'h0},
    {4'd12, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1111_2222_3333_4444, 64'hDEAD_BEEF_0000_0001},
    {4'd15, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 64'h1}
  };

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'd0, 4'd1: return "R3";
      4'd2, 4'd3: return "R4";
      4'd4, 4'd5: return "R5";
      4'd6:       return "R6";
      4'd7:       return "R7";
      4'd8:       return "R8";
      4'd9:       return "R9";
      4'd10:      return "R10";
      4'd11:      return "R11";
      default:    return "R12";
    endcase
  endfunction

  function automatic logic [63:0] model(input logic [3:0] op, input logic [63:0] a,
                                        input logic [63:0] b, input logic [63:0] c);
    longint p [4];
    longint s;
    logic [63:0] r;
    logic [63:0] t;
    bit sg;
    sg = (op == 1) || (op == 3) || (op == 5) || (op == 7) || (op == 10) || (op == 11);
    for (int i = 0; i < 4; i++) begin
      longint x, y;
      x = sg ? longint'($signed(a[i*16 +: 16])) : longint'({48'd0, a[i*16 +: 16]});
      y = sg ? longint'($signed(b[i*16 +: 16])) : longint'({48'd0, b[i*16 +: 16]});
      p[i] = x * y;
    end
    r = '0;
    case (op)
      0, 1: for (int i = 0; i < 4; i++) begin t = p[i]; r[i*16 +: 16] = t[15:0]; end
      2, 3: for (int i = 0; i < 4; i++) begin t = p[i]; r[i*16 +: 16] = t[31:16]; end
      4, 5: begin
        t = p[0] + p[1]; r[31:0] = t[31:0];
        t = p[2] + p[3]; r[63:32] = t[31:0];
      end
      6, 7: r = p[0] + p[1] + p[2] + p[3];
      8: begin
        s = 0;
        for (int j = 0; j < 8; j++) begin
          longint d;
          d = longint'({56'd0, a[j*8 +: 8]}) - longint'({56'd0, b[j*8 +: 8]});
          s += (d < 0) ? -d : d;
        end
        r = s;
      end
      9: begin
        s = 0;
        for (int i = 0; i < 4; i++) begin
          longint d;
          d = longint'({48'd0, a[i*16 +: 16]}) - longint'({48'd0, b[i*16 +: 16]});
          s += (d < 0) ? -d : d;
        end
        r = s;
      end
      10: r = c + p[0];
      11: r = c + p[0] + p[1];
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] op, input logic [63:0] a, input logic [63:0] b,
                       input logic [63:0] c);
    opcode = op; src_a = a; src_b = b; acc_in = c; in_valid = 1'b1;
  endtask

  task automatic run_one(input logic [3:0] op, input logic [63:0] a, input logic [63:0] b,
                         input logic [63:0] c, input logic [63:0] exp, input string req);
    @(negedge clk);
    drive(op, a, b, c);
    @(negedge clk);
    in_valid = 1'b0;
    check(req, {63'd0, out_valid}, 64'd1);
    check(req, result, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] exp_prev;
    logic [63:0] held;
    string       req_prev;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", {63'd0, out_valid}, 64'd0);
    check("R1", result, 64'd0);
    rst = 1'b0;

    // table walked back to back: capture and presentation in the same cycle
    exp_prev = '0;
    req_prev = "";
    for (int k = 0; k < NV; k++) begin
      logic [3:0]  vop;
      logic [63:0] va, vb, vc;
      {vop, va, vb, vc} = VECS[k];
      @(negedge clk);
      if (k > 0) begin
        check(req_prev, {63'd0, out_valid}, 64'd1);
        check(req_prev, result, exp_prev);
      end
      drive(vop, va, vb, vc);
      exp_prev = model(vop, va, vb, vc);
      req_prev = req_of(vop);
    end
    @(negedge clk);
    in_valid = 1'b0;
    check(req_prev, result, exp_prev);

    // random back-to-back stream
    for (int k = 0; k < 400; k++) begin
      logic [3:0]  rop;
      logic [63:0] ra, rb, rc;
      rop = 4'($urandom_range(0, 15));
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      rc = {$urandom, $urandom};
      @(negedge clk);
      if (k > 0) check(req_prev, result, exp_prev);
      drive(rop, ra, rb, rc);
      exp_prev = model(rop, ra, rb, rc);
      req_prev = req_of(rop);
    end
    @(negedge clk);
    in_valid = 1'b0;
    check(req_prev, result, exp_prev);

    // 0x8000 x 0x8000 in every lane, both interpretations
    run_one(4'd0, {4{16'h8000}}, {4{16'h8000}}, 64'h0, 64'h0, "R3");
    run_one(4'd1, {4{16'h8000}}, {4{16'h8000}}, 64'h0, 64'h0, "R3");
    run_one(4'd2, {4{16'h8000}}, {4{16'h8000}}, 64'h0, 64'h4000_4000_4000_4000, "R4");
    run_one(4'd3, {4{16'h8000}}, {4{16'h8000}}, 64'h0, 64'h4000_4000_4000_4000, "R4");
    run_one(4'd4, {4{16'h8000}}, {4{16'h8000}}, 64'h0, 64'h8000_0000_8000_0000, "R5");
    run_one(4'd5, {4{16'h8000}}, {4{16'h8000}}, 64'h0, 64'h8000_0000_8000_0000, "R5");
    run_one(4'd6, {4{16'h8000}}, {4{16'h8000}}, 64'h0, 64'h0000_0001_0000_0000, "R6");
    run_one(4'd7, {4{16'h8000}}, {4{16'h8000}}, 64'h0, 64'h0000_0001_0000_0000, "R7");
    // 0x8000 x 0x7FFF separates signed from unsigned
    run_one(4'd2, 64'h8000, 64'h7FFF, 64'h0, 64'h3FFF, "R4");
    run_one(4'd3, 64'h8000, 64'h7FFF, 64'h0, 64'hC000, "R4");
    run_one(4'd6, 64'h8000, 64'h7FFF, 64'h0, 64'h3FFF_8000, "R6");
    run_one(4'd7, 64'h8000, 64'h7FFF, 64'h0, 64'hFFFF_FFFF_C000_8000, "R7");
    // SAD extremes
    run_one(4'd8, {64{1'b1}}, 64'h0, 64'h0, 64'h7F8, "R8");
    run_one(4'd9, 64'h0, {64{1'b1}}, 64'h0, 64'h3FFFC, "R9");
    // scalar multiply-adds
    run_one(4'd10, 64'hFFFF, 64'h0002, 64'h5, 64'h3, "R10");
    run_one(4'd10, 64'hFFFF, 64'h0002, 64'h0, 64'hFFFF_FFFF_FFFF_FFFE, "R10");
    run_one(4'd11, 64'hFFFF_FFFF_0003_FFFF, 64'h7777_7777_0002_0004, 64'h10, 64'h12, "R11");
    // unused codes
    run_one(4'd13, {64{1'b1}}, {64{1'b1}}, {64{1'b1}}, 64'h0, "R12");
    run_one(4'd14, 64'h8000, 64'h8000, 64'h1, 64'h0, "R12");

    // R2: result holds while idle even as inputs change
    run_one(4'd9, 64'h0, 64'h0005, 64'h0, 64'h5, "R9");
    held = result;
    @(negedge clk);
    drive(4'd6, {64{1'b1}}, {64{1'b1}}, 64'h0);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R2", {63'd0, out_valid}, 64'd0);
    check("R2", result, held);

    // R1: reset coinciding with a valid operation
    @(negedge clk);
    drive(4'd7, 64'h0001_0001_0001_0001, 64'h0002_0002_0002_0002, 64'h0);
    rst = 1'b1;
    @(negedge clk);
    check("R1", {63'd0, out_valid}, 64'd0);
    check("R1", result, 64'd0);
    in_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    check("R2", {63'd0, out_valid}, 64'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule